// File: doc/BRIEF.md
# DRAM Memory Hole Remap Decoder

This block turns a host physical address into an address in the DRAM array. The window just below 4 GiB is set aside for device registers, so the DRAM cells that would answer there cannot be reached at those addresses. When relocation is enabled, those cells answer instead in a window that starts at 4 GiB. The host address input is 36 bits wide so that this window can be reached.

Three configuration registers set the behaviour: the base of the device hole, the top of installed memory (the array size), and the relocation enable. The size of the relocated window is derived from these values. It equals the installed memory that sits at or above the hole base, which with the reset values is 512 MiB. A host address inside the hole never hits, because the cycle belongs to device space. When relocation is disabled, the DRAM behind the hole is lost.

Each request with valid set is decoded in one registered stage. There is no backpressure. The output carries a hit flag and the array address, and the address reads zero on a miss.

Top module: `hole_remap_dec`

## Requirements
- R1: After reset the hole base is 0xE000_0000, the top of installed memory is 0x1_0000_0000 (4 GiB), relocation is disabled, and out_valid, out_hit and out_addr are all zero.
- R2: A host address below the hole base and below the effective top hits, and out_addr equals the host address.
- R3: A host address at or above the hole base and below 0x1_0000_0000 misses, whatever the enable setting.
- R4: With relocation enabled, a host address A with 0x1_0000_0000 <= A < 0x1_0000_0000 + (effective top - hole base) hits, and out_addr = A - 0x1_0000_0000 + hole base.
- R5: With relocation disabled, every host address at or above 0x1_0000_0000 misses.
- R6: A host address below the hole base but at or above the effective top misses. A host address past the end of the relocated window misses. When the effective top is at or below the hole base, the relocated window is empty.
- R7: When out_hit is low, out_addr is zero.
- R8: out_valid equals in_valid from one cycle earlier. A cycle without in_valid gives out_valid and out_hit low on the next cycle.
- R9: A pulse on cfg_we loads all three configuration values on that clock edge. A request presented in the same cycle as the write is decoded with the old values, and requests in later cycles use the new ones.
- R10: The effective top is the configured top clamped to 0x1_0000_0000. A larger value behaves exactly as 4 GiB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads the three configuration values |
| cfg_hole_base | input | 32 | New hole base |
| cfg_top | input | 33 | New top of installed memory (array size in bytes) |
| cfg_remap_en | input | 1 | New relocation enable |
| in_valid | input | 1 | Request valid |
| in_addr | input | 36 | Host physical address |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_hit | output | 1 | Address maps to DRAM |
| out_addr | output | 32 | DRAM array address, zero on miss |

## Verification
A wrong region decision appears as a flipped out_hit on the cycle after the request, so the tests put probes on both sides of every boundary: the hole base, 4 GiB, the top of memory and the end of the relocated window. A wrong offset in the relocation arithmetic leaves out_hit correct but changes out_addr, and this shows on the same cycle. A stale or mis-loaded configuration register first appears on the request after the write. It is caught by placing a request in the same cycle as a write and another request in the cycle after it.

// File: rtl/hole_remap_pkg.sv
package hole_remap_pkg;

  // Region decided for one host address.
  typedef enum logic [1:0] {
    RGN_LOW_HIT   = 2'd0,
    RGN_HOLE      = 2'd1,
    RGN_REMAP_HIT = 2'd2,
    RGN_MISS      = 2'd3
  } region_e;

endpackage

// File: rtl/hole_remap_cfg.sv
module hole_remap_cfg #(
  parameter int unsigned         ARR_AW   = 32,
  parameter logic [ARR_AW-1:0]   HOLE_RST = 32'hE000_0000,
  parameter logic [ARR_AW:0]     TOP_RST  = 33'h1_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ARR_AW-1:0] wr_hole,
  input  logic [ARR_AW:0]   wr_top,
  input  logic              wr_remap,
  output logic [ARR_AW-1:0] hole_q,
  output logic [ARR_AW:0]   top_eff,
  output logic [ARR_AW:0]   disp_size,
  output logic              remap_q
);
  localparam int unsigned     TOP_W  = ARR_AW + 1;
  localparam logic [TOP_W-1:0] FOUR_G = {1'b1, {ARR_AW{1'b0}}};

  logic [TOP_W-1:0] top_q;

  // Installed memory cannot exceed the span of the array address.
  function automatic logic [TOP_W-1:0] clamp_top(input logic [TOP_W-1:0] t);
    return (t > FOUR_G) ? FOUR_G : t;
  endfunction

  // Bytes of installed memory shadowed by the hole.
  function automatic logic [TOP_W-1:0] shadow_span(input logic [TOP_W-1:0] t,
                                                   input logic [ARR_AW-1:0] h);
    logic [TOP_W-1:0] hw;
    hw = {1'b0, h};
    return (t > hw) ? (t - hw) : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hole_q  <= HOLE_RST;
      top_q   <= TOP_RST;
      remap_q <= 1'b0;
    end else if (wr_en) begin
      hole_q  <= wr_hole;
      top_q   <= wr_top;
      remap_q <= wr_remap;
    end
  end

  assign top_eff   = clamp_top(top_q);
  assign disp_size = shadow_span(top_eff, hole_q);

endmodule

// File: rtl/hole_remap_classify.sv
module hole_remap_classify
  import hole_remap_pkg::*;
#(
  parameter int unsigned HOST_AW = 36,
  parameter int unsigned ARR_AW  = 32
) (
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [ARR_AW-1:0]  hole_base,
  input  logic [ARR_AW:0]    top_eff,
  input  logic [ARR_AW:0]    disp_size,
  input  logic               remap_en,
  output region_e            rgn
);
  localparam int unsigned      PAD_A = HOST_AW - ARR_AW;
  localparam int unsigned      PAD_T = HOST_AW - ARR_AW - 1;
  localparam logic [HOST_AW-1:0] BOUND = {{PAD_T{1'b0}}, 1'b1, {ARR_AW{1'b0}}};

  function automatic logic [HOST_AW-1:0] widen_a(input logic [ARR_AW-1:0] v);
    return {{PAD_A{1'b0}}, v};
  endfunction

  function automatic logic [HOST_AW-1:0] widen_t(input logic [ARR_AW:0] v);
    return {{PAD_T{1'b0}}, v};
  endfunction

  logic [HOST_AW-1:0] ofs;

  always_comb begin
    ofs = host_addr - BOUND;
    if (host_addr < widen_a(hole_base)) begin
      rgn = (host_addr < widen_t(top_eff)) ? RGN_LOW_HIT : RGN_MISS;
    end else if (host_addr < BOUND) begin
      rgn = RGN_HOLE;
    end else if (remap_en && (ofs < widen_t(disp_size))) begin
      rgn = RGN_REMAP_HIT;
    end else begin
      rgn = RGN_MISS;
    end
  end

endmodule

// File: rtl/hole_remap_xlate.sv
module hole_remap_xlate
  import hole_remap_pkg::*;
#(
  parameter int unsigned ARR_AW = 32
) (
  input  region_e           rgn,
  input  logic [ARR_AW-1:0] addr_lo,
  input  logic [ARR_AW-1:0] hole_base,
  output logic              hit,
  output logic [ARR_AW-1:0] arr_addr
);
  // Subtracting 4 GiB leaves the low bits unchanged, so the relocated
  // array address is the low part of the host address plus the hole base.
  function automatic logic [ARR_AW-1:0] relocate(input logic [ARR_AW-1:0] lo,
                                                 input logic [ARR_AW-1:0] h);
    return lo + h;
  endfunction

  always_comb begin
    unique case (rgn)
      RGN_LOW_HIT: begin
        hit      = 1'b1;
        arr_addr = addr_lo;
      end
      RGN_REMAP_HIT: begin
        hit      = 1'b1;
        arr_addr = relocate(addr_lo, hole_base);
      end
      default: begin
        hit      = 1'b0;
        arr_addr = '0;
      end
    endcase
  end

endmodule

// File: rtl/hole_remap_stage.sv
module hole_remap_stage #(
  parameter int unsigned ARR_AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_d,
  input  logic              hit_d,
  input  logic [ARR_AW-1:0] addr_d,
  output logic              vld_q,
  output logic              hit_q,
  output logic [ARR_AW-1:0] addr_q
);
  logic take;
  assign take = vld_d & hit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      hit_q  <= take;
      addr_q <= take ? addr_d : '0;
    end
  end

endmodule

// File: rtl/hole_remap_dec.sv
module hole_remap_dec
  import hole_remap_pkg::*;
#(
  parameter int unsigned       HOST_AW  = 36,
  parameter int unsigned       ARR_AW   = 32,
  parameter logic [ARR_AW-1:0] HOLE_RST = 32'hE000_0000,
  parameter logic [ARR_AW:0]   TOP_RST  = 33'h1_0000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ARR_AW-1:0]  cfg_hole_base,
  input  logic [ARR_AW:0]    cfg_top,
  input  logic               cfg_remap_en,
  input  logic               in_valid,
  input  logic [HOST_AW-1:0] in_addr,
  output logic               out_valid,
  output logic               out_hit,
  output logic [ARR_AW-1:0]  out_addr
);
  logic [ARR_AW-1:0] cfg_hole_q;
  logic [ARR_AW:0]   cfg_top_eff;
  logic [ARR_AW:0]   cfg_disp;
  logic              cfg_remap_q;
  region_e           cls_rgn;
  logic              cls_low_hit;
  logic              cls_remap_hit;
  logic              xl_hit;
  logic [ARR_AW-1:0] xl_addr;

  hole_remap_cfg #(
    .ARR_AW  (ARR_AW),
    .HOLE_RST(HOLE_RST),
    .TOP_RST (TOP_RST)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_hole  (cfg_hole_base),
    .wr_top   (cfg_top),
    .wr_remap (cfg_remap_en),
    .hole_q   (cfg_hole_q),
    .top_eff  (cfg_top_eff),
    .disp_size(cfg_disp),
    .remap_q  (cfg_remap_q)
  );

  hole_remap_classify #(
    .HOST_AW(HOST_AW),
    .ARR_AW (ARR_AW)
  ) u_cls (
    .host_addr(in_addr),
    .hole_base(cfg_hole_q),
    .top_eff  (cfg_top_eff),
    .disp_size(cfg_disp),
    .remap_en (cfg_remap_q),
    .rgn      (cls_rgn)
  );

  // Named decode events for the checker.
  assign cls_low_hit   = (cls_rgn == RGN_LOW_HIT);
  assign cls_remap_hit = (cls_rgn == RGN_REMAP_HIT);

  hole_remap_xlate #(
    .ARR_AW(ARR_AW)
  ) u_xl (
    .rgn      (cls_rgn),
    .addr_lo  (in_addr[ARR_AW-1:0]),
    .hole_base(cfg_hole_q),
    .hit      (xl_hit),
    .arr_addr (xl_addr)
  );

  hole_remap_stage #(
    .ARR_AW(ARR_AW)
  ) u_stg (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_d (in_valid),
    .hit_d (xl_hit),
    .addr_d(xl_addr),
    .vld_q (out_valid),
    .hit_q (out_hit),
    .addr_q(out_addr)
  );

endmodule

// File: rtl/hole_remap_chk.sv
module hole_remap_chk #(
  parameter int unsigned HOST_AW = 36,
  parameter int unsigned ARR_AW  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [HOST_AW-1:0] in_addr,
  input logic               out_valid,
  input logic               out_hit,
  input logic [ARR_AW-1:0]  out_addr,
  input logic [ARR_AW-1:0]  hole_q,
  input logic [ARR_AW:0]    top_eff,
  input logic               remap_q,
  input logic               cls_low_hit,
  input logic               cls_remap_hit
);
  localparam int unsigned        PAD_A = HOST_AW - ARR_AW;
  localparam logic [HOST_AW-1:0] BOUND = {{(PAD_A-1){1'b0}}, 1'b1, {ARR_AW{1'b0}}};

  logic above_4g;
  logic in_hole;
  assign above_4g = (in_addr >= BOUND);
  assign in_hole  = !above_4g && (in_addr >= {{PAD_A{1'b0}}, hole_q});

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_hit));

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hit |-> (out_addr == '0));

  // R3
  hole_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_hole) |=> !out_hit);

  // R5
  no_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !remap_q && above_4g) |=> !out_hit);

  // R2
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_low_hit) |=> (out_hit && (out_addr == $past(in_addr[ARR_AW-1:0]))));

  // R4
  remap_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_remap_hit) |=>
      (out_hit && (out_addr == ARR_AW'($past(in_addr[ARR_AW-1:0]) + $past(hole_q)))));

  // R6
  below_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!out_hit || ({1'b0, out_addr} < $past(top_eff))));

endmodule

bind hole_remap_dec hole_remap_chk #(
  .HOST_AW(HOST_AW),
  .ARR_AW (ARR_AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_addr      (in_addr),
  .out_valid    (out_valid),
  .out_hit      (out_hit),
  .out_addr     (out_addr),
  .hole_q       (cfg_hole_q),
  .top_eff      (cfg_top_eff),
  .remap_q      (cfg_remap_q),
  .cls_low_hit  (cls_low_hit),
  .cls_remap_hit(cls_remap_hit)
);

// File: tb/hole_remap_dec_bench.sv
`timescale 1ns/1ps
module hole_remap_dec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_hole_base = '0;
  logic [32:0] cfg_top = '0;
  logic        cfg_remap_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [35:0] in_addr = '0;
  logic        out_valid;
  logic        out_hit;
  logic [31:0] out_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  hole_remap_dec u_hole_remap_dec (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hole_base(cfg_hole_base),
    .cfg_top(cfg_top), .cfg_remap_en(cfg_remap_en), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit), .out_addr(out_addr)
  );

  typedef struct packed {
    logic        en;
    logic [35:0] addr;
    logic        hit;
    logic [31:0] arr;
  } vec_t;

  // Default hole 0xE000_0000, top 4 GiB; only the enable is changed.
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 36'h0_0000_0000, 1'b1, 32'h0000_0000},  // R2
    '{1'b0, 36'h0_DFFF_FFFF, 1'b1, 32'hDFFF_FFFF},  // R2 last below hole
    '{1'b0, 36'h0_E000_0000, 1'b0, 32'h0},          // R3 hole base
    '{1'b0, 36'h0_FFFF_FFFF, 1'b0, 32'h0},          // R3 hole top
    '{1'b0, 36'h1_0000_0000, 1'b0, 32'h0},          // R5
    '{1'b0, 36'h1_1FFF_FFFF, 1'b0, 32'h0},          // R5
    '{1'b1, 36'h0_1234_5678, 1'b1, 32'h1234_5678},  // R2
    '{1'b1, 36'h0_DFFF_FFFF, 1'b1, 32'hDFFF_FFFF},  // R2
    '{1'b1, 36'h0_E000_0000, 1'b0, 32'h0},          // R3
    '{1'b1, 36'h0_FFFF_FFFF, 1'b0, 32'h0},          // R3
    '{1'b1, 36'h1_0000_0000, 1'b1, 32'hE000_0000},  // R4 window start
    '{1'b1, 36'h1_1FFF_FFFF, 1'b1, 32'hFFFF_FFFF},  // R4 window end
    '{1'b1, 36'h1_2000_0000, 1'b0, 32'h0},          // R6 past window
    '{1'b1, 36'hF_FFFF_FFFF, 1'b0, 32'h0}           // R6 top of host space
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Independent expectation, computed with 64-bit arithmetic.
  task automatic model(input logic [63:0] a, input logic [63:0] hole, input logic [63:0] top,
                       input bit en, output bit hit, output logic [63:0] arr);
    logic [63:0] four_g;
    logic [63:0] te;
    four_g = 64'h1_0000_0000;
    te  = (top > four_g) ? four_g : top;
    hit = 1'b0;
    arr = '0;
    if (a < hole) begin
      if (a < te) begin hit = 1'b1; arr = a; end
    end else if (a >= four_g && en && te > hole && (a - four_g) < (te - hole)) begin
      hit = 1'b1;
      arr = a - four_g + hole;
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic set_cfg(input logic [31:0] h, input logic [32:0] t, input bit en);
    cfg_we = 1'b1; cfg_hole_base = h; cfg_top = t; cfg_remap_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [35:0] a, input bit exp_hit,
                       input logic [31:0] exp_arr);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " hit"},   64'(out_hit),   64'(exp_hit));
    chk({tag, " addr"},  64'(out_addr),  64'(exp_arr));
  endtask

  task automatic probe_model(input string tag, input logic [35:0] a, input logic [31:0] h,
                             input logic [32:0] t, input bit en);
    bit ph;
    logic [63:0] pa;
    model(64'(a), 64'(h), 64'(t), en, ph, pa);
    probe(tag, a, ph, pa[31:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 out_hit",   64'(out_hit),   64'd0);
    chk("R1 out_addr",  64'(out_addr),  64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset configuration seen through decoding
    probe("R1 below default hole", 36'h0_DFFF_FFFF, 1'b1, 32'hDFFF_FFFF);
    probe("R1 default hole",       36'h0_E000_0000, 1'b0, 32'h0);
    probe("R1 relocation off",     36'h1_0000_0000, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      set_cfg(32'hE000_0000, 33'h1_0000_0000, TBL[i].en);
      probe($sformatf("R2-6 vector %0d", i), TBL[i].addr, TBL[i].hit, TBL[i].arr);
    end

    // R6 small memory: top at 2 GiB, below the hole, window empty
    set_cfg(32'hE000_0000, 33'h0_8000_0000, 1'b1);
    probe_model("R6 last installed", 36'h0_7FFF_FFFF, 32'hE000_0000, 33'h0_8000_0000, 1'b1);
    probe_model("R6 first absent",   36'h0_8000_0000, 32'hE000_0000, 33'h0_8000_0000, 1'b1);
    probe_model("R6 empty window",   36'h1_0000_0000, 32'hE000_0000, 33'h0_8000_0000, 1'b1);

    // R4/R6 partial shadow: top 0xF000_0000
    set_cfg(32'hE000_0000, 33'h0_F000_0000, 1'b1);
    probe_model("R4 partial window end", 36'h1_0FFF_FFFF, 32'hE000_0000, 33'h0_F000_0000, 1'b1);
    probe_model("R6 partial past end",   36'h1_1000_0000, 32'hE000_0000, 33'h0_F000_0000, 1'b1);

    // R10 top above 4 GiB clamps, hole moved to 3 GiB
    set_cfg(32'hC000_0000, 33'h1_8000_0000, 1'b1);
    probe_model("R10 below hole",   36'h0_BFFF_FFFF, 32'hC000_0000, 33'h1_8000_0000, 1'b1);
    probe_model("R10 window end",   36'h1_3FFF_FFFF, 32'hC000_0000, 33'h1_8000_0000, 1'b1);
    probe_model("R10 clamped miss", 36'h1_4000_0000, 32'hC000_0000, 33'h1_8000_0000, 1'b1);

    // R9 write and request in the same cycle: old config (relocation off) applies
    set_cfg(32'hE000_0000, 33'h1_0000_0000, 1'b0);
    cfg_we = 1'b1; cfg_remap_en = 1'b1;
    in_valid = 1'b1; in_addr = 36'h1_0000_0000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 same-cycle hit", 64'(out_hit), 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next-cycle hit",  64'(out_hit),  64'd1);
    chk("R9 next-cycle addr", 64'(out_addr), 64'hE000_0000);

    // R8 back-to-back requests and an idle cycle
    in_valid = 1'b1; in_addr = 36'h0_0000_1000;
    @(negedge clk);
    chk("R8 first valid", 64'(out_valid), 64'd1);
    chk("R8 first addr",  64'(out_addr),  64'h1000);
    in_addr = 36'h1_0000_2000;
    @(negedge clk);
    chk("R8 second valid", 64'(out_valid), 64'd1);
    chk("R8 second addr",  64'(out_addr),  64'hE000_2000);
    in_valid = 1'b0; in_addr = 36'h0_0000_3000;
    @(negedge clk);
    chk("R8 idle valid", 64'(out_valid), 64'd0);
    chk("R8 idle hit",   64'(out_hit),   64'd0);
    // R7 address reads zero without a hit
    chk("R7 idle addr",  64'(out_addr),  64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule